// File: doc/BRIEF.md
# Synchronized Output Flashing Generator

This block produces the on/off drive for eight low-side output stages arranged as two groups of four (nibbles). A slow flash clock, asynchronous to the system clock, is brought into the fast clock domain and its rising edges advance a shared prescale counter. Each nibble picks its own flash period from that counter through a two-bit code. The code gives 1, 2, 4 or 16 times the flash period.

Every stage has a latch bit that asks for the driver to be on. It also has a pulse-enable bit. With the pulse-enable bit clear, the stage is driven steadily from its latch. With it set, the latch is gated by the selected flash wave. A per-nibble output-mode bit decides whether that nibble drives at all. A shutdown flag switches every stage off. The pin outputs are active low: a 0 means the low-side driver is conducting.

The latch byte and the pulse-enable byte are loaded through write strobes. All drive outputs are registered.

Top module: `flash_drive_gen`

## Requirements
- R1: While reset is low, and after reset until something is written, every bit of `drive_n_o` is 1. Reset clears the latch byte, the pulse-enable byte and the prescale counter.
- R2: `flash_i` passes through a two-flop synchronizer before use. A change on `flash_i` applied before clock edge k reaches a pulsing stage whose divisor code is 00 in `drive_n_o` just after edge k+2, and not earlier.
- R3: Each nibble's divisor code works as follows. Code 00 uses the synchronized flash level. Code 01 uses bit 0 of the count of synchronized rising flash edges. Code 10 uses bit 1 of that count. Code 11 uses bit 3. The lower nibble reads `div_code_i[1:0]` and the upper nibble reads `div_code_i[3:2]`.
- R4: A stage whose pulse-enable bit is 0, in an output-mode nibble and without shutdown, is driven low exactly when its latch bit is 1. The output shows the latch state one cycle after the latch register holds it.
- R5: A stage whose pulse-enable bit is 1 is driven low only when its latch bit is 1 and the selected wave of its nibble is 1.
- R6: With `shutdown_i` high at a clock edge, every bit of `drive_n_o` is 1 after that edge.
- R7: With `mode_i[0]` at 0 (lower) or `mode_i[1]` at 0 (upper), the four bits of that nibble are 1 after the edge, whatever the latch holds.
- R8: `out_data_i` is loaded into the latch byte only on an edge with `out_we_i` high. `pen_data_i` is loaded into the pulse-enable byte only on an edge with `pen_we_i` high. At other times both bytes hold.
- R9: The rising-edge count wraps modulo 16, so code 11 gives a wave whose period is 16 flash periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast system clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| flash_i | input | 1 | Slow flash clock, asynchronous |
| out_data_i | input | 8 | New latch byte, 1 = driver on |
| out_we_i | input | 1 | Load strobe for the latch byte |
| pen_data_i | input | 8 | New pulse-enable byte, 1 = stage pulses |
| pen_we_i | input | 1 | Load strobe for the pulse-enable byte |
| div_code_i | input | 4 | Divisor codes, [1:0] lower nibble, [3:2] upper nibble |
| mode_i | input | 2 | Output mode per nibble, 1 = outputs |
| shutdown_i | input | 1 | Thermal or supply shutdown, forces all stages off |
| drive_n_o | output | 8 | Active-low driver enables, bit i = stage i |

## Verification
A wrong latch or pulse-enable bit shows on the matching pin one cycle after the register takes it, provided the stage is in an output nibble and is not gated off. A miscounted prescaler is harder to see. For the ÷2 tap it shows at the next flash edge. For the ÷16 tap it may stay hidden for up to eight flash periods, so the divided phases are run long enough to cover several full periods of every tap. A synchronizer that is too short or too long moves every pulsing edge by one clock. Comparing each cycle against a reference model catches that on the first flash transition.

// File: rtl/flash_gen_pkg.sv
package flash_gen_pkg;

    typedef enum logic [1:0] {
        DIV_1  = 2'b00,
        DIV_2  = 2'b01,
        DIV_4  = 2'b10,
        DIV_16 = 2'b11
    } flash_div_e;

    localparam int unsigned DIV_CODE_W = 2;

endpackage

// File: rtl/flash_sync.sv
module flash_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic flash_i,
    output logic level_o,
    output logic rise_o
);
    localparam int unsigned TOP = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] chain;
        logic                   last;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.chain = {s_q.chain[TOP-1:0], flash_i};
        s_d.last  = s_q.chain[TOP];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign level_o = s_q.chain[TOP];
    assign rise_o  = s_q.chain[TOP] & ~s_q.last;

endmodule

// File: rtl/flash_prescale.sv
module flash_prescale #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             rise_i,
    output logic [CNT_W-1:0] cnt_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pre_t;

    pre_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (rise_i) begin
            p_d.cnt = p_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    assign cnt_o = p_q.cnt;

endmodule

// File: rtl/nibble_gate.sv
module nibble_gate
    import flash_gen_pkg::*;
#(
    parameter int unsigned NIB_W = 4,
    parameter int unsigned CNT_W = 4
) (
    input  logic             level_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  flash_div_e       div_i,
    input  logic             out_en_i,
    input  logic             shutdown_i,
    input  logic [NIB_W-1:0] latch_i,
    input  logic [NIB_W-1:0] pen_i,
    output logic [NIB_W-1:0] on_o
);
    localparam int unsigned TAP_2  = 0;
    localparam int unsigned TAP_4  = 1;
    localparam int unsigned TAP_16 = CNT_W - 1;

    logic wave;
    logic allow;

    always_comb begin
        unique case (div_i)
            DIV_1:   wave = level_i;
            DIV_2:   wave = cnt_i[TAP_2];
            DIV_4:   wave = cnt_i[TAP_4];
            default: wave = cnt_i[TAP_16];
        endcase
    end

    assign allow = out_en_i & ~shutdown_i;

    for (genvar s = 0; s < NIB_W; s++) begin : g_stage
        assign on_o[s] = allow & latch_i[s] & (~pen_i[s] | wave);
    end

endmodule

// File: rtl/flash_drive_gen.sv
module flash_drive_gen
    import flash_gen_pkg::*;
#(
    parameter int unsigned NUM_NIB     = 2,
    parameter int unsigned NIB_W       = 4,
    parameter int unsigned CNT_W       = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          flash_i,
    input  logic [NUM_NIB*NIB_W-1:0]      out_data_i,
    input  logic                          out_we_i,
    input  logic [NUM_NIB*NIB_W-1:0]      pen_data_i,
    input  logic                          pen_we_i,
    input  logic [NUM_NIB*DIV_CODE_W-1:0] div_code_i,
    input  logic [NUM_NIB-1:0]            mode_i,
    input  logic                          shutdown_i,
    output logic [NUM_NIB*NIB_W-1:0]      drive_n_o
);
    localparam int unsigned NUM_STAGES = NUM_NIB * NIB_W;

    typedef struct packed {
        logic [NUM_STAGES-1:0] latch;
        logic [NUM_STAGES-1:0] pen;
        logic [NUM_STAGES-1:0] drv;
    } regs_t;

    regs_t regs_d, regs_q;

    logic                  flash_lvl;
    logic                  flash_rise;
    logic [CNT_W-1:0]      pre_cnt;
    logic [NUM_STAGES-1:0] stage_on;
    logic [NUM_STAGES-1:0] latch_q;

    flash_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) i_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .flash_i (flash_i),
        .level_o (flash_lvl),
        .rise_o  (flash_rise)
    );

    flash_prescale #(
        .CNT_W (CNT_W)
    ) i_prescale (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .rise_i (flash_rise),
        .cnt_o  (pre_cnt)
    );

    for (genvar n = 0; n < NUM_NIB; n++) begin : g_nib
        nibble_gate #(
            .NIB_W (NIB_W),
            .CNT_W (CNT_W)
        ) i_gate (
            .level_i    (flash_lvl),
            .cnt_i      (pre_cnt),
            .div_i      (flash_div_e'(div_code_i[n*DIV_CODE_W +: DIV_CODE_W])),
            .out_en_i   (mode_i[n]),
            .shutdown_i (shutdown_i),
            .latch_i    (regs_q.latch[n*NIB_W +: NIB_W]),
            .pen_i      (regs_q.pen[n*NIB_W +: NIB_W]),
            .on_o       (stage_on[n*NIB_W +: NIB_W])
        );
    end

    always_comb begin
        regs_d     = regs_q;
        regs_d.drv = stage_on;
        if (out_we_i) begin
            regs_d.latch = out_data_i;
        end
        if (pen_we_i) begin
            regs_d.pen = pen_data_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign latch_q   = regs_q.latch;
    assign drive_n_o = ~regs_q.drv;

endmodule

module flash_drive_gen_chk #(
    parameter int unsigned NUM_NIB = 2,
    parameter int unsigned NIB_W   = 4,
    parameter int unsigned CNT_W   = 4
) (
    input logic                     clk_i,
    input logic                     rst_ni,
    input logic                     shutdown_i,
    input logic [NUM_NIB-1:0]       mode_i,
    input logic [NUM_NIB*NIB_W-1:0] drive_n_o,
    input logic [NUM_NIB*NIB_W-1:0] latch_q,
    input logic                     flash_rise,
    input logic [CNT_W-1:0]         pre_cnt
);
    localparam int unsigned NUM_STAGES = NUM_NIB * NIB_W;

    // R6: shutdown forces every stage off on the following cycle
    a_r6_shutdown_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
        shutdown_i |=> (drive_n_o == {NUM_STAGES{1'b1}}));

    // R4 / R5: no stage conducts unless its latch bit was set
    a_r5_needs_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) or 1'b1 |=> ((~drive_n_o & ~$past(latch_q)) == '0));

    // R3: prescale count holds between synchronized rising edges
    a_r3_count_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !flash_rise |=> $stable(pre_cnt));

    // R9: prescale count steps by one and wraps on each rising edge
    a_r9_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flash_rise |=> (pre_cnt == CNT_W'($past(pre_cnt) + 1'b1)));

    // R7: a nibble in input mode is never driven
    for (genvar n = 0; n < NUM_NIB; n++) begin : g_mode
        a_r7_idle_nibble: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !mode_i[n] |=> (drive_n_o[n*NIB_W +: NIB_W] == {NIB_W{1'b1}}));
    end

endmodule

bind flash_drive_gen flash_drive_gen_chk #(
    .NUM_NIB (NUM_NIB),
    .NIB_W   (NIB_W),
    .CNT_W   (CNT_W)
) i_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shutdown_i (shutdown_i),
    .mode_i     (mode_i),
    .drive_n_o  (drive_n_o),
    .latch_q    (latch_q),
    .flash_rise (flash_rise),
    .pre_cnt    (pre_cnt)
);

// File: tb/test_flash_drive_gen.sv
module test_flash_drive_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       flash = 1'b0;
    logic [7:0] out_data = '0;
    logic       out_we = 1'b0;
    logic [7:0] pen_data = '0;
    logic       pen_we = 1'b0;
    logic [3:0] div_code = '0;
    logic [1:0] mode = '0;
    logic       sd = 1'b0;
    logic [7:0] drive_n;

    int    n_checks = 0;
    int    n_errors = 0;
    string cur_req  = "R1";
    bit    done     = 1'b0;

    bit   flash_run    = 1'b0;
    logic flash_manual = 1'b0;
    int   flash_ctr    = 0;
    localparam int HALF = 6;

    always #2.5 clk = ~clk;

    flash_drive_gen i_flash_drive_gen (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .flash_i    (flash),
        .out_data_i (out_data),
        .out_we_i   (out_we),
        .pen_data_i (pen_data),
        .pen_we_i   (pen_we),
        .div_code_i (div_code),
        .mode_i     (mode),
        .shutdown_i (sd),
        .drive_n_o  (drive_n)
    );

    // Flash source, changed away from the active edge
    always @(negedge clk) begin
        if (flash_run) begin
            flash_ctr = flash_ctr + 1;
            if (flash_ctr >= HALF) begin
                flash_ctr = 0;
                flash = ~flash;
            end
        end else begin
            flash_ctr = 0;
            flash = flash_manual;
        end
    end

    // Behavioural reference model
    int   p1, p2, p3, edges;
    logic [7:0] m_lat, m_pen, exp_on;

    always @(posedge clk) begin
        if (!rst_n) begin
            p1 = 0; p2 = 0; p3 = 0; edges = 0;
            m_lat = '0; m_pen = '0; exp_on = '0;
        end else begin
            for (int i = 0; i < 8; i++) begin
                int nib;
                int code;
                int wave;
                nib  = i / 4;
                code = (nib == 0) ? int'(div_code[1:0]) : int'(div_code[3:2]);
                case (code)
                    0:       wave = p2;
                    1:       wave = edges % 2;
                    2:       wave = (edges / 2) % 2;
                    default: wave = (edges / 8) % 2;
                endcase
                exp_on[i] = mode[nib] && !sd && m_lat[i] && (!m_pen[i] || wave != 0);
            end
            if (p2 != 0 && p3 == 0) edges = (edges + 1) % 16;
            if (out_we) m_lat = out_data;
            if (pen_we) m_pen = pen_data;
            p3 = p2; p2 = p1; p1 = int'(flash);
        end
    end

    // Compare on every clock
    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_checks++;
            if (drive_n !== ~exp_on) begin
                n_errors++;
                $display("FAIL %s model: drive_n=%h expected=%h at %0t", cur_req, drive_n, ~exp_on, $time);
            end
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: drive_n=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_out(input logic [7:0] v);
        out_data = v; out_we = 1'b1;
        cyc(1);
        out_we = 1'b0;
    endtask

    task automatic wr_pen(input logic [7:0] v);
        pen_data = v; pen_we = 1'b1;
        cyc(1);
        pen_we = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: run did not end, actual=timeout expected=done");
        finish_run();
    end

    initial begin
        // R1: reset state
        cyc(3);
        chk("R1", drive_n, 8'hFF);
        rst_n = 1'b1;
        mode  = 2'b11;
        cyc(4);
        chk("R1", drive_n, 8'hFF);

        // R8: data without strobe is ignored
        cur_req  = "R8";
        out_data = 8'hFF;
        pen_data = 8'hFF;
        cyc(3);
        chk("R8", drive_n, 8'hFF);

        // R4: steady drive from latch
        cur_req = "R4";
        wr_out(8'hA5);
        cyc(1);
        chk("R4", drive_n, ~8'hA5);
        wr_out(8'h3C);
        cyc(1);
        chk("R4", drive_n, ~8'h3C);

        // R2: synchronizer latency with code 00
        cur_req = "R2";
        wr_out(8'hFF);
        wr_pen(8'hFF);
        cyc(4);
        chk("R2", drive_n, 8'hFF);
        flash_manual = 1'b1;
        cyc(1);
        chk("R2", drive_n, 8'hFF);
        cyc(1);
        chk("R2", drive_n, 8'hFF);
        cyc(1);
        chk("R2", drive_n, 8'h00);
        flash_manual = 1'b0;
        cyc(4);
        chk("R2", drive_n, 8'hFF);

        // R5: pulsing lower nibble, steady upper nibble
        cur_req  = "R5";
        wr_pen(8'h0F);
        flash_run = 1'b1;
        cyc(100);

        // R3: lower /2, upper /16
        cur_req  = "R3";
        div_code = 4'b1101;
        wr_pen(8'hFF);
        cyc(500);

        // R9: upper /16 across several wraps, lower /4
        cur_req  = "R9";
        div_code = 4'b1110;
        wr_out(8'h5A);
        cyc(900);

        // R6: shutdown
        cur_req = "R6";
        wr_out(8'hFF);
        wr_pen(8'h00);
        sd = 1'b1;
        cyc(2);
        chk("R6", drive_n, 8'hFF);
        sd = 1'b0;
        cyc(2);
        chk("R6", drive_n, 8'h00);

        // R7: nibble modes
        cur_req = "R7";
        mode = 2'b01;
        cyc(2);
        chk("R7", drive_n, 8'hF0);
        mode = 2'b10;
        cyc(2);
        chk("R7", drive_n, 8'h0F);
        mode = 2'b00;
        cyc(2);
        chk("R7", drive_n, 8'hFF);
        mode = 2'b11;

        // R8: pulse-enable data without strobe is ignored
        cur_req  = "R8";
        pen_data = 8'hFF;
        cyc(60);
        chk("R8", drive_n, 8'h00);

        // R1: reset mid-run clears everything
        cur_req = "R1";
        rst_n = 1'b0;
        cyc(2);
        chk("R1", drive_n, 8'hFF);
        rst_n = 1'b1;
        cyc(30);
        chk("R1", drive_n, 8'hFF);

        finish_run();
    end

endmodule